// File: doc/BRIEF.md
# Pipelined Execute Stage with Operand Bypass

This block is the execute stage of a five-stage, 32-bit in-order pipeline. Each cycle it takes the decoded instruction and its two register operands from the decode/execute latch. It also takes two late values: the ALU result now held in the execute/memory latch, and the value being written back from the memory/writeback latch. Six bypass flags, three for each operand, are produced outside this block and choose which of these sources each operand uses.

The resolved operands feed an ALU. Under opcode 0 the ALU decodes the function field to select add, exclusive-or, inverted-and, signed set-greater-than or logical variable right shift. Opcode 47 selects a conditional add/subtract: the block subtracts when the first operand is strictly positive and adds otherwise. On each rising clock edge the ALU result, the resolved second operand and the instruction word are registered toward the memory stage.

Top module: `exec_stage`

## Requirements
- R1: With no bypass flag set for an operand, that operand is the value from the decode/execute latch (`a_in` for operand A, `b_in` for operand B).
- R2: When an operand's memory-stage bypass flag is set, the operand is `mem_alu_in`. This takes priority over that operand's two writeback flags.
- R3: When an operand's memory-stage flag is clear and either of its writeback flags is set, the operand is `wb_value_in`.
- R4: With opcode 0 (bits 31:26) and function 32 (bits 5:0), the result is A + B modulo 2^32.
- R5: Opcode 0 with function 50 gives A XOR B. Function 51 gives NOT(A AND B).
- R6: Opcode 0 with function 52 gives 1 when A > B as signed 32-bit values, and 0 otherwise.
- R7: Opcode 0 with function 53 gives A shifted right logically by B[4:0].
- R8: With opcode 47, the result is A − B when A is signed-positive (greater than zero), and A + B otherwise. This includes A = 0.
- R9: Any other opcode, or opcode 0 with any other function code, gives a result of 0.
- R10: On each rising edge `exmem_alu` takes the result, `exmem_b` takes the resolved B operand, and `exmem_ir` takes `ir_in`. The outputs therefore lag the inputs by exactly one cycle.
- R11: A synchronous active-high reset clears all three registered outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ir_in | input | 32 | Instruction from decode/execute latch |
| a_in | input | 32 | First register operand from decode |
| b_in | input | 32 | Second register operand from decode |
| mem_alu_in | input | 32 | ALU result held in the execute/memory latch |
| wb_value_in | input | 32 | Value being written back |
| fwd_a_mem | input | 1 | Operand A from memory stage |
| fwd_a_wb_alu | input | 1 | Operand A from writeback (ALU producer) |
| fwd_a_wb_load | input | 1 | Operand A from writeback (load producer) |
| fwd_b_mem | input | 1 | Operand B from memory stage |
| fwd_b_wb_alu | input | 1 | Operand B from writeback (ALU producer) |
| fwd_b_wb_load | input | 1 | Operand B from writeback (load producer) |
| exmem_alu | output | 32 | Registered ALU result |
| exmem_b | output | 32 | Registered resolved operand B |
| exmem_ir | output | 32 | Registered instruction |

## Verification
The block has only one register stage, so any fault in the operand selection or the ALU shows up at `exmem_alu` or `exmem_b` on the very next rising edge. A wrong bypass priority appears only when the memory flag and a writeback flag are set together, so those combinations are driven deliberately. A wrong sign treatment appears only for operands with bit 31 set, or for A = 0 under opcode 47, so those values are driven deliberately too. Every cycle is compared against a behavioural model, which means a single bad result is caught in the cycle it appears.

// File: rtl/exec_pkg.sv
package exec_pkg;
    localparam int XLEN      = 32;
    localparam int OPW       = 6;
    localparam int FNW       = 6;
    localparam int SHW       = $clog2(XLEN);
    localparam int OP_LSB    = XLEN - OPW;

    localparam logic [OPW-1:0] OP_RTYPE = 6'd0;
    localparam logic [OPW-1:0] OP_CONDAS = 6'd47;

    typedef enum logic [FNW-1:0] {
        FN_ADD  = 6'd32,
        FN_XOR  = 6'd50,
        FN_NAND = 6'd51,
        FN_SGT  = 6'd52,
        FN_SRLV = 6'd53
    } func_e;

    typedef enum logic [1:0] {
        SRC_REG = 2'd0,
        SRC_MEM = 2'd1,
        SRC_WB  = 2'd2
    } src_e;

    typedef struct packed {
        logic mem;
        logic wb_alu;
        logic wb_load;
    } byp_t;

    typedef struct packed {
        logic [XLEN-1:0] alu;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] ir;
    } exmem_t;

    function automatic src_e pick_src(input byp_t f);
        if (f.mem)                  return SRC_MEM;
        if (f.wb_alu || f.wb_load)  return SRC_WB;
        return SRC_REG;
    endfunction
endpackage

// File: rtl/exec_bypass.sv
module exec_bypass
    import exec_pkg::*;
#(
    parameter int W = XLEN
) (
    input  byp_t         flags,
    input  logic [W-1:0] reg_val,
    input  logic [W-1:0] mem_val,
    input  logic [W-1:0] wb_val,
    output logic [W-1:0] operand
);
    src_e sel;
    always_comb begin
        sel = pick_src(flags);
        unique case (sel)
            SRC_MEM: operand = mem_val;
            SRC_WB:  operand = wb_val;
            default: operand = reg_val;
        endcase
    end
endmodule

// File: rtl/exec_alu.sv
module exec_alu
    import exec_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] ir,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] result
);
    localparam int SW = $clog2(W);
    logic [OPW-1:0] opc;
    logic [FNW-1:0] fn;
    logic           a_pos;
    always_comb begin
        opc    = ir[W-1 -: OPW];
        fn     = ir[FNW-1:0];
        a_pos  = ($signed(opa) > 0);
        result = '0;
        if (opc == OP_RTYPE) begin
            case (fn)
                FN_ADD:  result = opa + opb;
                FN_XOR:  result = opa ^ opb;
                FN_NAND: result = ~(opa & opb);
                FN_SGT:  result = {{(W-1){1'b0}}, ($signed(opa) > $signed(opb))};
                FN_SRLV: result = opa >> opb[SW-1:0];
                default: result = '0;
            endcase
        end else if (opc == OP_CONDAS) begin
            result = a_pos ? (opa - opb) : (opa + opb);
        end
    end
endmodule

// File: rtl/exec_stage.sv
module exec_stage
    import exec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [XLEN-1:0]  ir_in,
    input  logic [XLEN-1:0]  a_in,
    input  logic [XLEN-1:0]  b_in,
    input  logic [XLEN-1:0]  mem_alu_in,
    input  logic [XLEN-1:0]  wb_value_in,
    input  logic             fwd_a_mem,
    input  logic             fwd_a_wb_alu,
    input  logic             fwd_a_wb_load,
    input  logic             fwd_b_mem,
    input  logic             fwd_b_wb_alu,
    input  logic             fwd_b_wb_load,
    output logic [XLEN-1:0]  exmem_alu,
    output logic [XLEN-1:0]  exmem_b,
    output logic [XLEN-1:0]  exmem_ir
);
    localparam int NOPS = 2;

    byp_t            flg [NOPS];
    logic [XLEN-1:0] regv [NOPS];
    logic [XLEN-1:0] opv  [NOPS];
    logic [XLEN-1:0] alu_res;
    exmem_t          q;

    assign flg[0]  = '{mem: fwd_a_mem, wb_alu: fwd_a_wb_alu, wb_load: fwd_a_wb_load};
    assign flg[1]  = '{mem: fwd_b_mem, wb_alu: fwd_b_wb_alu, wb_load: fwd_b_wb_load};
    assign regv[0] = a_in;
    assign regv[1] = b_in;

    for (genvar i = 0; i < NOPS; i++) begin : g_byp
        exec_bypass #(.W(XLEN)) u_byp (
            .flags   (flg[i]),
            .reg_val (regv[i]),
            .mem_val (mem_alu_in),
            .wb_val  (wb_value_in),
            .operand (opv[i])
        );
    end

    exec_alu #(.W(XLEN)) u_alu (
        .ir     (ir_in),
        .opa    (opv[0]),
        .opb    (opv[1]),
        .result (alu_res)
    );

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= '{alu: alu_res, b: opv[1], ir: ir_in};
    end

    assign exmem_alu = q.alu;
    assign exmem_b   = q.b;
    assign exmem_ir  = q.ir;
endmodule

// File: rtl/exec_stage_chk.sv
module exec_stage_chk
    import exec_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] ir_in,
    input logic [XLEN-1:0] b_in,
    input logic [XLEN-1:0] mem_alu_in,
    input logic [XLEN-1:0] wb_value_in,
    input logic            fwd_b_mem,
    input logic            fwd_b_wb_alu,
    input logic            fwd_b_wb_load,
    input logic [XLEN-1:0] exmem_alu,
    input logic [XLEN-1:0] exmem_b,
    input logic [XLEN-1:0] exmem_ir
);
    logic seen;
    always_ff @(posedge clk) seen <= 1'b1;

    // R10
    ir_pipe_chk: assert property (@(posedge clk) disable iff (rst)
        seen && !$past(rst) |-> exmem_ir == $past(ir_in));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        seen && $past(rst) |-> (exmem_alu == '0 && exmem_b == '0 && exmem_ir == '0));

    // R2
    b_mem_prio_chk: assert property (@(posedge clk) disable iff (rst)
        seen && !$past(rst) && $past(fwd_b_mem) |-> exmem_b == $past(mem_alu_in));

    // R3
    b_wb_chk: assert property (@(posedge clk) disable iff (rst)
        seen && !$past(rst) && !$past(fwd_b_mem) && ($past(fwd_b_wb_alu) || $past(fwd_b_wb_load))
        |-> exmem_b == $past(wb_value_in));

    // R1
    b_reg_chk: assert property (@(posedge clk) disable iff (rst)
        seen && !$past(rst) && !$past(fwd_b_mem) && !$past(fwd_b_wb_alu) && !$past(fwd_b_wb_load)
        |-> exmem_b == $past(b_in));

    // R9
    unknown_op_chk: assert property (@(posedge clk) disable iff (rst)
        seen && !$past(rst) && $past(ir_in[XLEN-1 -: OPW]) != OP_RTYPE
            && $past(ir_in[XLEN-1 -: OPW]) != OP_CONDAS |-> exmem_alu == '0);
endmodule

bind exec_stage exec_stage_chk u_chk (
    .clk(clk), .rst(rst), .ir_in(ir_in), .b_in(b_in),
    .mem_alu_in(mem_alu_in), .wb_value_in(wb_value_in),
    .fwd_b_mem(fwd_b_mem), .fwd_b_wb_alu(fwd_b_wb_alu), .fwd_b_wb_load(fwd_b_wb_load),
    .exmem_alu(exmem_alu), .exmem_b(exmem_b), .exmem_ir(exmem_ir)
);

// File: tb/exec_stage_test.sv
module exec_stage_test;
    logic        clk = 0;
    logic        rst;
    logic [31:0] ir_in, a_in, b_in, mem_alu_in, wb_value_in;
    logic        fam, fawa, fawl, fbm, fbwa, fbwl;
    logic [31:0] exmem_alu, exmem_b, exmem_ir;

    int checks = 0, fails = 0;

    exec_stage uut (
        .clk(clk), .rst(rst), .ir_in(ir_in), .a_in(a_in), .b_in(b_in),
        .mem_alu_in(mem_alu_in), .wb_value_in(wb_value_in),
        .fwd_a_mem(fam), .fwd_a_wb_alu(fawa), .fwd_a_wb_load(fawl),
        .fwd_b_mem(fbm), .fwd_b_wb_alu(fbwa), .fwd_b_wb_load(fbwl),
        .exmem_alu(exmem_alu), .exmem_b(exmem_b), .exmem_ir(exmem_ir)
    );

    always #2 clk = ~clk;

    logic [31:0] exp_alu, exp_b, exp_ir;
    string       tag;

    function automatic logic [31:0] mk_ir(input int opc, input int fn);
        return {opc[5:0], 20'h12345, fn[5:0]};
    endfunction

    task automatic cmp(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic step(input string t, input logic [31:0] ir, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] m, input logic [31:0] w,
                        input logic [5:0] f);
        longint sa, sb;
        logic [31:0] ea, eb, r;
        int opc, fn;
        ir_in = ir; a_in = a; b_in = b; mem_alu_in = m; wb_value_in = w;
        {fam, fawa, fawl, fbm, fbwa, fbwl} = f;
        ea = fam ? m : ((fawa || fawl) ? w : a);
        eb = fbm ? m : ((fbwa || fbwl) ? w : b);
        sa = longint'($signed(ea)); sb = longint'($signed(eb));
        opc = int'(ir[31:26]); fn = int'(ir[5:0]);
        r = 0;
        if (opc == 0) begin
            if (fn == 32) r = ea + eb;
            else if (fn == 50) r = ea ^ eb;
            else if (fn == 51) r = ~(ea & eb);
            else if (fn == 52) r = (sa > sb) ? 1 : 0;
            else if (fn == 53) r = ea >> eb[4:0];
        end else if (opc == 47) begin
            r = (sa > 0) ? ea - eb : ea + eb;
        end
        @(posedge clk);
        #1;
        cmp({t, " R10 alu"}, exmem_alu, r);
        cmp({t, " R10 b"}, exmem_b, eb);
        cmp({t, " R10 ir"}, exmem_ir, ir);
    endtask

    initial begin : watchdog
        #400000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1;
        ir_in = 0; a_in = 0; b_in = 0; mem_alu_in = 0; wb_value_in = 0;
        {fam, fawa, fawl, fbm, fbwa, fbwl} = 0;
        @(posedge clk); @(posedge clk); #1;
        // R11 reset state
        cmp("R11 alu", exmem_alu, 0);
        cmp("R11 b", exmem_b, 0);
        cmp("R11 ir", exmem_ir, 0);
        rst = 0;
        // R4 add, R1 no bypass
        step("R4 R1", mk_ir(0,32), 32'd9, 32'd17, 32'hAAAA, 32'h5555, 6'b000000);
        step("R4 wrap", mk_ir(0,32), 32'hFFFFFFFF, 32'd2, 0, 0, 6'b000000);
        // R5
        step("R5 xor", mk_ir(0,50), 32'hF0F0_1234, 32'h0FF0_4321, 0, 0, 0);
        step("R5 nand", mk_ir(0,51), 32'hFF00_FF00, 32'h0FF0_0FF0, 0, 0, 0);
        // R6 signed
        step("R6 gt", mk_ir(0,52), 32'd5, 32'hFFFFFFFF, 0, 0, 0);
        step("R6 lt", mk_ir(0,52), 32'h80000000, 32'd1, 0, 0, 0);
        step("R6 eq", mk_ir(0,52), 32'd7, 32'd7, 0, 0, 0);
        // R7
        step("R7 srl", mk_ir(0,53), 32'h80000000, 32'h0000_0024, 0, 0, 0);
        step("R7 srl31", mk_ir(0,53), 32'hF0000000, 32'd31, 0, 0, 0);
        // R8
        step("R8 pos", mk_ir(47,0), 32'd10, 32'd3, 0, 0, 0);
        step("R8 zero", mk_ir(47,0), 32'd0, 32'd3, 0, 0, 0);
        step("R8 neg", mk_ir(47,0), 32'hFFFFFFF0, 32'd3, 0, 0, 0);
        // R9
        step("R9 badfn", mk_ir(0,33), 32'd4, 32'd4, 0, 0, 0);
        step("R9 badop", mk_ir(12,32), 32'd4, 32'd4, 0, 0, 0);
        // R2 / R3 bypass combos
        step("R2 a mem", mk_ir(0,32), 1, 2, 32'd100, 32'd1000, 6'b100000);
        step("R2 prio", mk_ir(0,32), 1, 2, 32'd100, 32'd1000, 6'b111111);
        step("R3 a wbalu", mk_ir(0,32), 1, 2, 32'd100, 32'd1000, 6'b010000);
        step("R3 a wbld", mk_ir(0,50), 1, 2, 32'd100, 32'd1000, 6'b001000);
        step("R3 b wbalu", mk_ir(0,32), 1, 2, 32'd100, 32'd1000, 6'b000010);
        step("R3 b wbld", mk_ir(0,52), 1, 2, 32'd100, 32'hFFFFFFFF, 6'b000001);
        step("R2 b mem", mk_ir(0,32), 1, 2, 32'd100, 32'd1000, 6'b000110);
        step("R8 fwd", mk_ir(47,0), 32'd0, 2, 32'd50, 32'd8, 6'b100001);
        for (int k = 0; k < 40; k++) begin
            step("R10 sweep", mk_ir((k%3==0)?47:0, 32+((k*7)%23)),
                 32'h9E3779B9*(k+1), 32'h7F4A7C15^(k*31), 32'h1111*k, 32'h2222*k,
                 6'(k*13));
        end
        // R11 mid-run reset
        rst = 1;
        @(posedge clk); #1;
        cmp("R11 alu2", exmem_alu, 0);
        cmp("R11 ir2", exmem_ir, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule